// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits on the controller side of a two-wire serial bus. Its job is to free the bus after a transfer was cut short, power was lost or a reset arrived mid-byte, which can leave a slave holding the data line low. When asked, it clocks SCL through open-drain output enables. After each clock pulse it looks at SDA while SCL is high. As soon as SDA reads released, it stops clocking, leaves both lines high for one more phase and then issues a start condition so every attached slave resynchronises. It then lets go of both lines and reports success.

If SDA is still low after the ninth pulse, the block gives up. It raises a failure flag, lets go of both lines and issues no start. A divider setting sets the length of each SCL phase in system clocks, with a floor of four clocks. A slave that stretches SCL low delays the high phase until the line is really seen high. The outputs are pull-low enables only: a 1 pulls a line low, a 0 releases it to the external pull-up.

Top module: `bus_recovery_seq`

## Requirements
- R1: In one recovery the block pulls SCL low at most nine times (nine pulses).
- R2: SDA is sampled at the end of every SCL high phase. Clocking stops after the first pulse whose sample reads high. If SDA is released after the slave has seen K rising SCL edges (K from 0 to 9), the recovery uses max(1,K) pulses.
- R3: On success, SDA is pulled low while SCL stays high (a start condition), exactly once. Before that, both lines have read high together for at least one phase.
- R4: While SCL pulses are being issued, SDA is never pulled. SDA changes with SCL high only at the start condition and at the final release after it, which forms a stop. So a successful run shows exactly one start and one stop.
- R5: `scl_oe` and `sda_oe` are pull-low enables (1 pulls the line low, 0 releases it). Once a recovery has ended, both are 0.
- R6: Every SCL low phase driven by the block lasts exactly P system clocks. P is `phase_div`, or 4 if `phase_div` is below 4, latched when the request is accepted.
- R7: The high-phase timer only advances while the synchronised SCL input reads high. A stretched SCL therefore delays sampling, and every SCL high time during recovery lasts at least P clocks.
- R8: If SDA still reads low after the ninth pulse, `fail` goes to 1, `done` stays 0 and no start or stop is produced.
- R9: On success `done` goes to 1 and `fail` stays 0. Both flags hold until the next request is accepted, which clears them.
- R10: A request is accepted only while the block is idle. A request made during a recovery changes neither its pulse count nor its single completion, and does not start another recovery.
- R11: After reset both enables are 0 and `done` and `fail` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| recover_req | input | 1 | Start a recovery (taken while idle) |
| phase_div | input | DIV_W | SCL phase length in system clocks (min 4) |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| done | output | 1 | Recovery ended with a start condition |
| fail | output | 1 | SDA still low after nine pulses |

## Verification
The hardest situation to reach is a slave that keeps SDA low for exactly nine, or more than nine, rising SCL edges while it also stretches SCL. In that case the last sample falls on a delayed high phase, and the run has to fail rather than start. The bench models a slave that releases SDA on its K-th rising edge and holds SCL low for a random number of extra clocks after every release. K is directed to 0, 1, 9 and 10 and also drawn at random up to 11. The short clamped divider and a second request made mid-recovery are driven as directed cases.

// File: rtl/brs_pkg.sv
// Shared types for the bus recovery sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package brs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // both lines released, waiting for a request
        ST_LOW,    // SCL pulled low for one phase
        ST_HIGH,   // SCL released, timer runs while SCL reads high
        ST_GAP,    // both released for one phase before the start
        ST_START   // SDA pulled low with SCL high
    } brs_state_e;
endpackage

// File: rtl/brs_sync.sv
// Multi-stage synchroniser for asynchronous line inputs.
// Assumes: lines idle high, so the stages reset to 1.
module brs_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        // Shift the raw line level through the stage chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], d_in[b]};
        end
        assign q_out[b] = chain[LAST];
    end
endmodule

// File: rtl/brs_phase_timer.sv
// Down-counter timing one SCL phase. A load sets it to len-1 and it
// counts down while run is high. expired is high once the count is zero.
// Assumes: load_val is at least 1.
module brs_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         expired
);
    logic [W-1:0] cnt;

    // Load on phase entry, otherwise count down while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= '0;
        else if (load)                cnt <= load_val - W'(1);
        else if (run && cnt != '0)    cnt <= cnt - W'(1);
    end

    assign expired = (cnt == '0);

    AST_TIMER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !run) |=> $stable(cnt)) else $error("timer moved while paused"); // R7
endmodule

// File: rtl/bus_recovery_seq.sv
// Bus recovery sequencer top. Issues up to MAX_PULSES SCL pulses through
// open-drain enables and samples SDA at the end of each high phase. Once
// SDA is seen high it holds both lines released for one phase, then pulls
// SDA low with SCL high (start) and lets both go. If SDA is still low
// after the last pulse it flags fail.
// Assumes: scl_in and sda_in are the wired-AND line levels and may be
// asynchronous. phase_div below MIN_PHASE is raised to MIN_PHASE.
module bus_recovery_seq
    import brs_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int MIN_PHASE   = 4,
    parameter int MAX_PULSES  = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             recover_req,
    input  logic [DIV_W-1:0] phase_div,
    output logic             scl_oe,
    output logic             sda_oe,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             done,
    output logic             fail
);
    localparam int               CNT_W  = $clog2(MAX_PULSES + 1);
    localparam logic [DIV_W-1:0] MIN_PH = DIV_W'(MIN_PHASE);
    localparam logic [CNT_W-1:0] LAST_P = CNT_W'(MAX_PULSES);

    brs_state_e       state, state_nx;
    logic [1:0]       lines_s;
    logic             scl_s, sda_s;
    logic [DIV_W-1:0] phase_q, phase_eff, load_val;
    logic [CNT_W-1:0] pulse_cnt;
    logic             accept, t_load, t_run, t_expired;

    brs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({scl_in, sda_in}),
        .q_out (lines_s)
    );
    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    // Clamp the divider to the minimum phase length.
    assign phase_eff = (phase_div < MIN_PH) ? MIN_PH : phase_div;
    assign accept    = (state == ST_IDLE) && recover_req;

    // Next-state decision for the recovery sequence.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nx = ST_LOW;
            ST_LOW:   if (t_expired) state_nx = ST_HIGH;
            ST_HIGH:  if (t_expired && scl_s) begin
                          if (sda_s)                    state_nx = ST_GAP;
                          else if (pulse_cnt == LAST_P) state_nx = ST_IDLE;
                          else                          state_nx = ST_LOW;
                      end
            ST_GAP:   if (t_expired && scl_s) state_nx = ST_START;
            ST_START: if (t_expired) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Timer controls: reload on each timed entry, run while SCL is high.
    always_comb begin
        t_load   = (state_nx != state) && (state_nx != ST_IDLE);
        load_val = accept ? phase_eff : phase_q;
        unique case (state)
            ST_LOW:  t_run = 1'b1;
            ST_IDLE: t_run = 1'b0;
            default: t_run = scl_s;
        endcase
    end

    brs_phase_timer #(.W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (load_val),
        .run      (t_run),
        .expired  (t_expired)
    );

    // State, latched phase length and pulse counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            phase_q   <= MIN_PH;
            pulse_cnt <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                phase_q   <= phase_eff;
                pulse_cnt <= '0;
            end else if (state == ST_LOW && state_nx == ST_HIGH) begin
                pulse_cnt <= pulse_cnt + CNT_W'(1);
            end
        end
    end

    // Outcome flags: set at the end of a recovery, cleared on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            fail <= 1'b0;
        end else if (accept) begin
            done <= 1'b0;
            fail <= 1'b0;
        end else begin
            if (state == ST_START && state_nx == ST_IDLE) done <= 1'b1;
            if (state == ST_HIGH  && state_nx == ST_IDLE) fail <= 1'b1;
        end
    end

    // Open-drain enables: 1 pulls the line low.
    assign scl_oe = (state == ST_LOW);
    assign sda_oe = (state == ST_START);

    AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_cnt <= LAST_P) else $error("too many pulses"); // R1
    AST_SDA_FREE_WHILE_CLOCKING: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOW || state == ST_HIGH) |-> !sda_oe) else $error("sda pulled while clocking"); // R4
    AST_START_WITH_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_s) && $past(state) == ST_GAP) else $error("start without bus free"); // R3
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!scl_oe && !sda_oe)) else $error("line held in idle"); // R5
    AST_PHASE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q >= MIN_PH) else $error("phase below floor"); // R6
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail)) else $error("done and fail together"); // R9
    AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && recover_req) |=> $stable(phase_q)) else $error("request taken while busy"); // R10
endmodule

// File: tb/bus_recovery_seq_bench.sv
module bus_recovery_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       recover_req = 1'b0;
    logic [7:0] phase_div = 8'd4;
    logic       scl_oe, sda_oe, scl_in, sda_in, done, fail;

    always #4 clk = ~clk;

    // Line and slave model state
    int stretch_left = 0;
    int stretch_max  = 0;
    int rises        = 0;
    int rel_k        = 0;

    assign scl_in = !scl_oe && (stretch_left == 0);
    assign sda_in = !sda_oe && (rises >= rel_k);

    bus_recovery_seq u_bus_recovery_seq (
        .clk(clk), .rst_n(rst_n), .recover_req(recover_req), .phase_div(phase_div),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_in(scl_in), .sda_in(sda_in),
        .done(done), .fail(fail)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // Monitor counters
    int exp_ph = 4;
    int n_pulses, n_start, n_stop, low_bad, high_bad, gap_bad, n_done_rise;
    int oe_run, high_run, bh_run;
    logic prev_oe = 0, prev_scl = 1, prev_sda = 1, prev_done = 0;

    task automatic clear_mon();
        n_pulses = 0; n_start = 0; n_stop = 0; low_bad = 0; high_bad = 0;
        gap_bad = 0; n_done_rise = 0; oe_run = 0;
    endtask

    always @(negedge clk) begin
        logic scl_now, sda_now;
        if (prev_oe && !scl_oe) stretch_left = (stretch_max == 0) ? 0 : int'($urandom_range(stretch_max, 0));
        else if (stretch_left > 0) stretch_left = stretch_left - 1;
        scl_now = !scl_oe && (stretch_left == 0);
        if (scl_now && !prev_scl) rises = rises + 1;
        sda_now = !sda_oe && (rises >= rel_k);
        if (scl_oe && !prev_oe) begin n_pulses++; oe_run = 1; end
        else if (scl_oe) oe_run++;
        else if (prev_oe && oe_run != exp_ph) low_bad++;
        if (prev_scl && !scl_now && high_run < exp_ph) high_bad++;
        if (prev_scl && scl_now && prev_sda && !sda_now) begin
            n_start++;
            if (bh_run < exp_ph) gap_bad++;
        end
        if (prev_scl && scl_now && !prev_sda && sda_now) n_stop++;
        if (done && !prev_done) n_done_rise++;
        high_run = scl_now ? high_run + 1 : 0;
        bh_run   = (scl_now && sda_now) ? bh_run + 1 : 0;
        prev_oe = scl_oe; prev_scl = scl_now; prev_sda = sda_now; prev_done = done;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_pulses(input int k);
        if (k > 9) return 9;
        if (k < 1) return 1;
        return k;
    endfunction

    function automatic int clamp_phase(input int d);
        return (d < 4) ? 4 : d;
    endfunction

    task automatic run_case(input int k, input int div, input int smax, input bit extra);
        int waited;
        @(negedge clk); #1;
        rel_k = k; rises = 0; stretch_max = smax;
        phase_div = 8'(div); exp_ph = clamp_phase(div);
        @(negedge clk); #1;
        clear_mon();
        recover_req = 1'b1;
        @(negedge clk); #1;
        recover_req = 1'b0;
        if (extra) begin
            repeat (3 * exp_ph) @(negedge clk);
            #1 recover_req = 1'b1;
            @(negedge clk); #1 recover_req = 1'b0;
        end
        waited = 0;
        while (!(done || fail) && waited < 20000) begin
            @(negedge clk); #1; waited++;
        end
        chk(waited < 20000, "R2 completion", waited, 0);
        repeat (6) @(negedge clk);
        #1;
        chk(n_pulses == exp_pulses(k), "R1/R2 pulse count", n_pulses, exp_pulses(k));
        chk(fail == (k > 9), "R8 fail flag", fail, k > 9);
        chk(done == (k <= 9), "R9 done flag", done, k <= 9);
        chk(n_start == ((k <= 9) ? 1 : 0), "R3 start count", n_start, (k <= 9) ? 1 : 0);
        chk(n_stop == ((k <= 9) ? 1 : 0), "R4 stop count", n_stop, (k <= 9) ? 1 : 0);
        chk(gap_bad == 0, "R3 bus free before start", gap_bad, 0);
        chk(low_bad == 0, "R6 low phase length", low_bad, 0);
        chk(high_bad == 0, "R7 high phase length", high_bad, 0);
        chk(!scl_oe && !sda_oe, "R5 lines released", {scl_oe, sda_oe}, 0);
        if (extra) chk(n_done_rise == ((k <= 9) ? 1 : 0), "R10 single completion", n_done_rise, (k <= 9) ? 1 : 0);
    endtask

    initial begin
        #(8 * 190000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!scl_oe && !sda_oe && !done && !fail, "R11 reset state",
            {scl_oe, sda_oe, done, fail}, 0);
        run_case(0, 6, 0, 0);
        run_case(1, 4, 2, 0);
        run_case(9, 5, 3, 0);
        run_case(10, 4, 4, 0);       // R8: never released within nine pulses
        run_case(5, 1, 0, 0);        // R6: divider clamped to 4
        run_case(3, 7, 5, 1);        // R10: request during recovery
        run_case(11, 6, 2, 1);       // R8 with R10
        for (int i = 0; i < 18; i++) begin
            run_case(int'($urandom_range(11, 0)), int'($urandom_range(12, 1)),
                     int'($urandom_range(6, 0)), 1'($urandom_range(1, 0)));
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule